// File: doc/BRIEF.md
# Clock Source Switch Sequencer

This block chooses which oscillator drives a small processor core whose instructions run through four phases. Each oscillator reaches the block as a tick waveform, sampled in one fast reference clock domain. Clocks are modelled as enables, not as gated clocks. A two-bit select input names the wanted source. The select codes are: 00 for the primary source, 01 for the secondary low-power oscillator, and 1x for the internal RC oscillator. A configuration input says what kind of oscillator the primary source is.

When the select input names a source other than the one in use, the block starts a switch. It freezes the phase sequencer in its first phase and counts falling edges of the incoming source. Only after a fixed number of those edges does it hand execution over to the new source. During the switch it clears the primary-running status bit. When the switch completes, it drops the enable of the source it left, to save power. If the primary source is itself the internal RC oscillator, no select change starts a switch.

A frequency-select field picks the internal oscillator rate. Any code other than the base rate clears a frequency-stable flag. The flag returns only after a parameterised number of internal RC ticks.

Top module: `clksw_top`

## Requirements
- R1: Select code 00 maps to the primary source (enable index 0), 01 to the secondary source (index 1), and 10 or 11 to the internal RC source (index 2). Out of reset the primary source is in use: prim_en=1, sec_en=0, rc_en=0, osc_ok=1.
- R2: A select change that starts a switch drives osc_ok low from the cycle after the change is seen. osc_ok returns high only when a switch to the primary source completes.
- R3: When prim_cfg equals the internal-RC code (PRIM_RC_CODE), select changes start no switch. The phases keep advancing on the primary tick, and osc_ok and the enables do not change.
- R4: While a switch is in progress, phase_oh is held at 4'b0001 (Q1) and cycle_end stays low. This holds until EDGE_CNT falling edges of the incoming source's tick have been counted. Falling edges of other ticks have no effect on the count.
- R5: During a switch, the enables of both the old and the incoming source are high. When the switch completes, only the new source's enable stays high.
- R6: When freq_sel equals BASE_FSEL (0), freq_stable is 1. Any other code clears freq_stable. It sets again after STAB_TICKS falling edges of the internal RC tick.
- R7: A change of freq_sel to a non-base code clears freq_stable and restarts the stabilization count from zero.
- R8: phase_oh is one-hot with bit 0 = Q1 through bit 3 = Q4. It advances one step per falling edge of the source in use, and ticks of other sources do not advance it. cycle_end pulses for one reference cycle on each Q4 to Q1 step.
- R9: A select change seen during a switch retargets the switch to the newly named source and restarts the edge count from zero. Edges counted for the earlier target no longer count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 2 | Requested source code |
| prim_cfg | input | PCFG_W | Configured kind of the primary oscillator |
| freq_sel | input | FSEL_W | Internal oscillator frequency code |
| prim_tick | input | 1 | Primary oscillator waveform |
| sec_tick | input | 1 | Secondary low-power oscillator waveform |
| rc_tick | input | 1 | Internal RC oscillator waveform |
| phase_oh | output | N_PHASE | One-hot instruction phase |
| cycle_end | output | 1 | One-cycle pulse at the end of each instruction cycle |
| osc_ok | output | 1 | High while the primary source drives the core |
| freq_stable | output | 1 | Internal oscillator frequency settled |
| prim_en | output | 1 | Primary oscillator enable |
| sec_en | output | 1 | Secondary oscillator enable |
| rc_en | output | 1 | Internal RC oscillator enable |

## Verification
The switch is driven with a straight move from the primary source to the internal RC source, with primary ticks injected during the hold. This shows that only the incoming source's edges count and that exactly EDGE_CNT of them release execution. A second switch is retargeted partway through. Seven edges of the new target must not release it, while the eighth must, which separates a restarted count from a continued one. Phase stepping is tried with ticks from the active and the inactive sources. The stabilization flag is tried with a base code, a non-base code and a second non-base code given mid-count, which tells a restart from a resumed count. A run with the primary configured as the RC oscillator confirms that select changes are then ignored.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

   typedef enum logic [1:0] {
      SRC_PRI = 2'd0,
      SRC_SEC = 2'd1,
      SRC_RC  = 2'd2
   } src_t;

   localparam int N_SRC = 3;

   // select code to source: 00 primary, 01 secondary, 1x internal RC
   function automatic src_t decode_sel(input logic [1:0] code);
      if (code[1])      return SRC_RC;
      else if (code[0]) return SRC_SEC;
      else              return SRC_PRI;
   endfunction

   function automatic logic pick_fall(input logic [N_SRC-1:0] falls, input src_t s);
      case (s)
         SRC_PRI: return falls[0];
         SRC_SEC: return falls[1];
         SRC_RC:  return falls[2];
         default: return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/clksw_fall_det.sv
module clksw_fall_det #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   output logic fall
);
   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("clksw_fall_det: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] samp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) samp_q <= '0;
      else        samp_q <= {samp_q[SYNC_STAGES-2:0], tick};
   end

   // older sample high, newer sample low
   assign fall = samp_q[SYNC_STAGES-1] & ~samp_q[SYNC_STAGES-2];

endmodule

// File: rtl/clksw_phase_seq.sv
module clksw_phase_seq #(
   parameter int N_PHASE = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hold,
   input  logic               adv,
   output logic [N_PHASE-1:0] phase,
   output logic               cyc_end
);
   if (N_PHASE < 2) begin : g_bad_phase
      $error("clksw_phase_seq: N_PHASE must be at least 2");
   end

   localparam logic [N_PHASE-1:0] FIRST = N_PHASE'(1);

   logic [N_PHASE-1:0] phase_q;
   logic               cyc_end_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= FIRST;
         cyc_end_q <= 1'b0;
      end else if (hold) begin
         phase_q   <= FIRST;
         cyc_end_q <= 1'b0;
      end else if (adv) begin
         phase_q   <= {phase_q[N_PHASE-2:0], phase_q[N_PHASE-1]};
         cyc_end_q <= phase_q[N_PHASE-1];
      end else begin
         cyc_end_q <= 1'b0;
      end
   end

   assign phase   = phase_q;
   assign cyc_end = cyc_end_q;

   // R8
   phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(phase_q) == 1);

   // R4
   hold_in_q1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (phase_q == FIRST) && !cyc_end_q);

   // R8
   cyc_end_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cyc_end_q) |-> phase_q[0]);

endmodule

// File: rtl/clksw_stab_timer.sv
module clksw_stab_timer #(
   parameter int              FSEL_W     = 3,
   parameter logic [FSEL_W-1:0] BASE_FSEL = '0,
   parameter int              STAB_TICKS = 125
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FSEL_W-1:0] freq_sel,
   input  logic              rc_fall,
   output logic              stable
);
   if (STAB_TICKS < 1) begin : g_bad_stab
      $error("clksw_stab_timer: STAB_TICKS must be at least 1");
   end

   localparam int SW = $clog2(STAB_TICKS + 1);

   logic [FSEL_W-1:0] fsel_q;
   logic [SW-1:0]     cnt_q;
   logic              stable_q;
   logic              fsel_chg;

   assign fsel_chg = (freq_sel != fsel_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fsel_q   <= BASE_FSEL;
         cnt_q    <= '0;
         stable_q <= 1'b1;
      end else if (fsel_chg) begin
         fsel_q   <= freq_sel;
         cnt_q    <= '0;
         stable_q <= (freq_sel == BASE_FSEL);
      end else if (!stable_q && rc_fall) begin
         if (cnt_q == SW'(STAB_TICKS - 1)) begin
            stable_q <= 1'b1;
            cnt_q    <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign stable = stable_q;

   // R7
   fsel_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fsel_chg && freq_sel != BASE_FSEL) |=> !stable_q);

   // R6
   stable_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stable_q) |-> ($past(rc_fall) || $past(fsel_chg)));

endmodule

// File: rtl/clksw_switch_ctl.sv
module clksw_switch_ctl
   import clksw_pkg::*;
#(
   parameter int              EDGE_CNT     = 8,
   parameter int              PCFG_W       = 3,
   parameter logic [PCFG_W-1:0] PRIM_RC_CODE = PCFG_W'(4)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        src_sel,
   input  logic [PCFG_W-1:0] prim_cfg,
   input  logic [N_SRC-1:0]  falls,
   output logic              hold,
   output logic              sys_adv,
   output logic              osc_ok,
   output logic [N_SRC-1:0]  en_vec
);
   if (EDGE_CNT < 1) begin : g_bad_edges
      $error("clksw_switch_ctl: EDGE_CNT must be at least 1");
   end

   localparam int CW = $clog2(EDGE_CNT + 1);

   src_t          cur_q, pend_q, target;
   logic          hold_q, osts_q, sw_allowed, pend_fall;
   logic [CW-1:0] cnt_q;

   assign target     = decode_sel(src_sel);
   assign sw_allowed = (prim_cfg != PRIM_RC_CODE);
   assign pend_fall  = pick_fall(falls, pend_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q  <= SRC_PRI;
         pend_q <= SRC_PRI;
         hold_q <= 1'b0;
         cnt_q  <= '0;
         osts_q <= 1'b1;
      end else if (hold_q) begin
         if (sw_allowed && target != pend_q) begin
            pend_q <= target;
            cnt_q  <= '0;
         end else if (pend_fall) begin
            if (cnt_q == CW'(EDGE_CNT - 1)) begin
               hold_q <= 1'b0;
               cur_q  <= pend_q;
               cnt_q  <= '0;
               osts_q <= (pend_q == SRC_PRI);
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end else if (sw_allowed && target != cur_q) begin
         hold_q <= 1'b1;
         pend_q <= target;
         cnt_q  <= '0;
         osts_q <= 1'b0;
      end
   end

   for (genvar g = 0; g < N_SRC; g++) begin : g_en
      assign en_vec[g] = (cur_q == src_t'(g)) || (hold_q && pend_q == src_t'(g));
   end

   assign hold    = hold_q;
   assign sys_adv = pick_fall(falls, cur_q) && !hold_q;
   assign osc_ok  = osts_q;

   // R2
   start_clears_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_q) |-> !osts_q);

   // R3
   no_switch_rc_prim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_allowed && !hold_q) |=> !hold_q);

   // R4
   edge_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CW'(EDGE_CNT));

   // R5
   release_single_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold_q) |-> $countones(en_vec) == 1);

endmodule

// File: rtl/clksw_top.sv
module clksw_top
   import clksw_pkg::*;
#(
   parameter int                N_PHASE      = 4,
   parameter int                EDGE_CNT     = 8,
   parameter int                SYNC_STAGES  = 2,
   parameter int                PCFG_W       = 3,
   parameter logic [PCFG_W-1:0] PRIM_RC_CODE = PCFG_W'(4),
   parameter int                FSEL_W       = 3,
   parameter logic [FSEL_W-1:0] BASE_FSEL    = '0,
   parameter int                STAB_TICKS   = 125
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         src_sel,
   input  logic [PCFG_W-1:0]  prim_cfg,
   input  logic [FSEL_W-1:0]  freq_sel,
   input  logic               prim_tick,
   input  logic               sec_tick,
   input  logic               rc_tick,
   output logic [N_PHASE-1:0] phase_oh,
   output logic               cycle_end,
   output logic               osc_ok,
   output logic               freq_stable,
   output logic               prim_en,
   output logic               sec_en,
   output logic               rc_en
);
   logic [N_SRC-1:0] tick_vec, fall_vec, en_vec;
   logic             hold, sys_adv;

   assign tick_vec = {rc_tick, sec_tick, prim_tick};

   for (genvar g = 0; g < N_SRC; g++) begin : g_fall
      clksw_fall_det #(.SYNC_STAGES(SYNC_STAGES)) u_fall (
         .clk  (clk),
         .rst_n(rst_n),
         .tick (tick_vec[g]),
         .fall (fall_vec[g])
      );
   end

   clksw_switch_ctl #(
      .EDGE_CNT    (EDGE_CNT),
      .PCFG_W      (PCFG_W),
      .PRIM_RC_CODE(PRIM_RC_CODE)
   ) u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_sel (src_sel),
      .prim_cfg(prim_cfg),
      .falls   (fall_vec),
      .hold    (hold),
      .sys_adv (sys_adv),
      .osc_ok  (osc_ok),
      .en_vec  (en_vec)
   );

   clksw_phase_seq #(.N_PHASE(N_PHASE)) u_phase (
      .clk    (clk),
      .rst_n  (rst_n),
      .hold   (hold),
      .adv    (sys_adv),
      .phase  (phase_oh),
      .cyc_end(cycle_end)
   );

   clksw_stab_timer #(
      .FSEL_W    (FSEL_W),
      .BASE_FSEL (BASE_FSEL),
      .STAB_TICKS(STAB_TICKS)
   ) u_stab (
      .clk     (clk),
      .rst_n   (rst_n),
      .freq_sel(freq_sel),
      .rc_fall (fall_vec[2]),
      .stable  (freq_stable)
   );

   assign prim_en = en_vec[0];
   assign sec_en  = en_vec[1];
   assign rc_en   = en_vec[2];

   // R1
   some_source_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_vec != '0);

   // R4
   hold_no_cycle_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> !cycle_end);

endmodule

// File: tb/clksw_top_tb.sv
module clksw_top_tb;
   localparam int STAB = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] src_sel = 2'b00;
   logic [2:0] prim_cfg = 3'd0;
   logic [2:0] freq_sel = 3'd0;
   logic [2:0] ticks = 3'b000;
   logic [3:0] phase_oh;
   logic       cycle_end, osc_ok, freq_stable, prim_en, sec_en, rc_en;

   int checks = 0;
   int fails = 0;
   int ce_cnt = 0;

   always #4 clk = ~clk;

   clksw_top #(.STAB_TICKS(STAB)) u_dut (
      .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .prim_cfg(prim_cfg),
      .freq_sel(freq_sel), .prim_tick(ticks[0]), .sec_tick(ticks[1]),
      .rc_tick(ticks[2]), .phase_oh(phase_oh), .cycle_end(cycle_end),
      .osc_ok(osc_ok), .freq_stable(freq_stable), .prim_en(prim_en),
      .sec_en(sec_en), .rc_en(rc_en)
   );

   always @(negedge clk) if (rst_n && cycle_end) ce_cnt++;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic pulse(input int s, input int n);
      for (int i = 0; i < n; i++) begin
         ticks[s] = 1'b1;
         repeat (3) @(negedge clk);
         ticks[s] = 1'b0;
         repeat (3) @(negedge clk);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      ticks = 3'b000;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   function automatic int ens();
      return {rc_en, sec_en, prim_en};
   endfunction

   task automatic t_reset();
      chk("R1 reset phase", phase_oh, 4'b0001);
      chk("R1 reset enables", ens(), 3'b001);
      chk("R1 reset osc_ok", osc_ok, 1);
      chk("R6 base stable", freq_stable, 1);
   endtask

   task automatic t_phases();
      int ce0;
      ce0 = ce_cnt;
      pulse(0, 1); chk("R8 Q2", phase_oh, 4'b0010);
      pulse(1, 2); chk("R8 other tick ignored", phase_oh, 4'b0010);
      pulse(0, 1); chk("R8 Q3", phase_oh, 4'b0100);
      pulse(0, 1); chk("R8 Q4", phase_oh, 4'b1000);
      chk("R8 no cycle_end yet", ce_cnt - ce0, 0);
      pulse(0, 1); chk("R8 wrap Q1", phase_oh, 4'b0001);
      chk("R8 one cycle_end", ce_cnt - ce0, 1);
   endtask

   task automatic t_to_rc();
      int ce0;
      pulse(0, 2);
      src_sel = 2'b11;
      repeat (2) @(negedge clk);
      ce0 = ce_cnt;
      chk("R2 osc_ok cleared", osc_ok, 0);
      chk("R4 held in Q1", phase_oh, 4'b0001);
      chk("R5 both enables in hold", ens(), 3'b101);
      pulse(0, 4);
      chk("R4 old source frozen", phase_oh, 4'b0001);
      pulse(2, 7);
      chk("R4 seven edges still hold", ens(), 3'b101);
      pulse(2, 1);
      chk("R5 primary dropped", ens(), 3'b100);
      chk("R4 no cycle_end in hold", ce_cnt - ce0, 0);
      chk("R2 osc_ok low on RC", osc_ok, 0);
      pulse(2, 1); chk("R4 resumes on RC", phase_oh, 4'b0010);
      pulse(0, 1); chk("R8 primary tick ignored", phase_oh, 4'b0010);
   endtask

   task automatic t_retarget();
      src_sel = 2'b01;
      repeat (2) @(negedge clk);
      chk("R1 secondary enabled", ens(), 3'b110);
      chk("R4 Q1 on retarget hold", phase_oh, 4'b0001);
      pulse(1, 5);
      src_sel = 2'b00;
      repeat (2) @(negedge clk);
      chk("R9 retarget enables", ens(), 3'b101);
      pulse(1, 3);
      chk("R9 old target edges ignored", ens(), 3'b101);
      pulse(0, 7);
      chk("R9 count restarted", ens(), 3'b101);
      chk("R2 osc_ok still low", osc_ok, 0);
      pulse(0, 1);
      chk("R9 switch done", ens(), 3'b001);
      chk("R2 osc_ok back on primary", osc_ok, 1);
   endtask

   task automatic t_freq();
      freq_sel = 3'd3;
      repeat (2) @(negedge clk);
      chk("R6 nonbase clears", freq_stable, 0);
      pulse(2, STAB - 1);
      chk("R6 not yet stable", freq_stable, 0);
      freq_sel = 3'd5;
      repeat (2) @(negedge clk);
      pulse(2, STAB - 1);
      chk("R7 count restarted", freq_stable, 0);
      pulse(2, 1);
      chk("R6 stable after interval", freq_stable, 1);
      freq_sel = 3'd0;
      repeat (2) @(negedge clk);
      chk("R6 base stable", freq_stable, 1);
   endtask

   task automatic t_prim_is_rc();
      prim_cfg = 3'd4;
      src_sel = 2'b00;
      do_reset();
      src_sel = 2'b10;
      repeat (2) @(negedge clk);
      chk("R3 osc_ok kept", osc_ok, 1);
      chk("R3 enables kept", ens(), 3'b001);
      pulse(0, 1);
      chk("R3 phases run", phase_oh, 4'b0010);
      src_sel = 2'b01;
      pulse(2, 8);
      chk("R3 no switch", ens(), 3'b001);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      do_reset();
      t_reset();
      t_phases();
      t_to_rc();
      t_retarget();
      t_freq();
      t_prim_is_rc();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule